// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Read and Output-Disable Pipeline

This block is the read side of a synchronous pipelined memory front end. Every command input is registered on the rising clock edge. The registered command then uses a small internal array, and read data comes out of a registered output stage one cycle after capture. Next to the data, the block drives an output-enable flag, which stands in for the control of a tri-state data bus, and a one-cycle valid strobe for each new read word.

A static mode input sets how fast a deselect turns the outputs off:

- **Single-cycle mode:** the outputs turn off in the same edge that captures the deselect.
- **Dual-cycle mode:** the deselect travels the full pipeline, like a read, so the outputs turn off one edge later.

A snooze input puts the block in standby. In standby the outputs are blanked and new commands are dropped, but the array keeps what it stores.

Commands are decoded from three inputs:

| Chip select `sel_n` | `wr_req` | `hold_req` | Command |
|---|---|---|---|
| high | any | any | deselect |
| low | 1 | any | write (write has priority) |
| low | 0 | 1 | hold |
| low | 0 | 0 | read |

Top module: `syncram_rdpipe`

## Requirements
- R1: A read of address A is driven before rising edge k. After edge k+1, `rdata` holds the word stored at A, and `oe` and `rvalid` are both 1. `rvalid` is 1 only in the cycle right after a read is presented, and `rvalid` is never 1 while `oe` is 0.
- R2: A write (`sel_n`=0, `wr_req`=1) that is captured at edge k stores `wdata` at `addr`. After edge k+1, `oe` is 0.
- R3: A read captured at the edge after a deselect drives `oe` high in the same cycle its data appears. Back-to-back reads present their words on consecutive cycles with `oe` high throughout.
- R4: A hold command (`sel_n`=0, `wr_req`=0, `hold_req`=1) starts no read. `rdata` and `oe` keep their previous values, and `rvalid` is 0. `rdata` only changes in a cycle where `rvalid` is 1, or on reset.
- R5: With `dual_desel`=0, a deselect captured at edge k while the previous captured command was a hold makes `oe` 0 after edge k.
- R6: With `dual_desel`=1, in that same sequence `oe` stays 1 after edge k and becomes 0 after edge k+1.
- R7: In both modes, a deselect captured right after a read does not cut off that read. The word is presented with `oe`=1 after the next edge, and after the edge that follows, `oe` and `rvalid` are both 0.
- R8: When `snooze` is 1 at an edge, `oe` and `rvalid` are 0 after that edge. Commands captured while `snooze` is 1 are ignored: writes store nothing and reads present nothing. A read already in flight is dropped.
- R9: Words written before a snooze period read back unchanged after it.
- R10: When `rst` is 1 at an edge, `oe`, `rvalid` and `rdata` are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dual_desel | input | 1 | Deselect latency mode: 0 = single-cycle, 1 = dual-cycle |
| snooze | input | 1 | Standby request, active high |
| sel_n | input | 1 | Chip select, active low; high means deselect |
| wr_req | input | 1 | Write command while selected |
| hold_req | input | 1 | Hold command while selected and not writing |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| oe | output | 1 | Output-enable flag for the data bus |
| rvalid | output | 1 | One-cycle strobe that marks a newly presented read word |

## Verification
The assertions assume that `dual_desel` is static and only changes while `rst` is high. The stimulus only switches modes inside a reset pulse. They also assume that every command input is defined at each edge. The bench drives all inputs on the falling edge and never leaves them unknown. Reads only target addresses the bench has already written, so every expected word comes from the bench's own model of the array. Snooze is raised and lowered only between commands, so each test knows exactly which edge first sees it.

// File: rtl/syncram_pkg.sv
package syncram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_HOLD = 2'd3
  } op_e;

  // Chip select wins, then write, then hold; otherwise read.
  function automatic op_e decode_op(input logic sel_n, input logic wr_req,
                                    input logic hold_req);
    op_e r;
    if (sel_n)         r = OP_IDLE;
    else if (wr_req)   r = OP_WR;
    else if (hold_req) r = OP_HOLD;
    else               r = OP_RD;
    return r;
  endfunction

endpackage

// File: rtl/syncram_cap.sv
module syncram_cap
  import syncram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snooze,
  input  logic          sel_n,
  input  logic          wr_req,
  input  logic          hold_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output op_e           in_op,
  output op_e           cap_op,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_wdata
);

  assign in_op = decode_op(sel_n, wr_req, hold_req);

  // Input register stage: commands seen during snooze are dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_op    <= OP_IDLE;
      cap_addr  <= '0;
      cap_wdata <= '0;
    end else begin
      cap_op    <= snooze ? OP_IDLE : in_op;
      cap_addr  <= addr;
      cap_wdata <= wdata;
    end
  end

endmodule

// File: rtl/syncram_array.sv
module syncram_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Storage is never reset, so contents survive snooze.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Registered read port with synchronous reset on the output register.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/syncram_drive.sv
module syncram_drive
  import syncram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dual_desel,
  input  logic snooze,
  input  op_e  in_op,
  input  op_e  cap_op,
  output logic oe,
  output logic rvalid
);

  logic oe_d;
  logic vld_d;

  always_comb begin
    oe_d = oe;
    unique case (cap_op)
      OP_RD:   oe_d = 1'b1;
      OP_WR:   oe_d = 1'b0;
      OP_IDLE: oe_d = 1'b0;
      OP_HOLD: if (!dual_desel && in_op == OP_IDLE) oe_d = 1'b0;
      default: oe_d = 1'b0;
    endcase
    if (snooze) oe_d = 1'b0;
    vld_d = (cap_op == OP_RD) && !snooze;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe     <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      oe     <= oe_d;
      rvalid <= vld_d;
    end
  end

  // R5: single-cycle mode cuts the outputs at the capture edge of a deselect
  p_scd_cut_r5: assert property (@(posedge clk) disable iff (rst)
    (!dual_desel && !snooze && cap_op == OP_HOLD && in_op == OP_IDLE) |=> !oe);

  // R6: dual-cycle mode keeps the outputs unchanged for one more edge
  p_dcd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (dual_desel && !snooze && cap_op == OP_HOLD) |=> (oe == $past(oe)));

endmodule

// File: rtl/syncram_rdpipe.sv
module syncram_rdpipe
  import syncram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dual_desel,
  input  logic          snooze,
  input  logic          sel_n,
  input  logic          wr_req,
  input  logic          hold_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          oe,
  output logic          rvalid
);

  op_e           in_op;
  op_e           cap_op;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_wdata;
  logic          arr_we;
  logic          arr_re;

  syncram_cap #(.AW(AW), .DW(DW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .snooze   (snooze),
    .sel_n    (sel_n),
    .wr_req   (wr_req),
    .hold_req (hold_req),
    .addr     (addr),
    .wdata    (wdata),
    .in_op    (in_op),
    .cap_op   (cap_op),
    .cap_addr (cap_addr),
    .cap_wdata(cap_wdata)
  );

  assign arr_we = (cap_op == OP_WR);
  assign arr_re = (cap_op == OP_RD) && !snooze;

  syncram_array #(.AW(AW), .DW(DW)) u_array (
    .clk  (clk),
    .rst  (rst),
    .we   (arr_we),
    .re   (arr_re),
    .addr (cap_addr),
    .wdata(cap_wdata),
    .rdata(rdata)
  );

  syncram_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .dual_desel(dual_desel),
    .snooze    (snooze),
    .in_op     (in_op),
    .cap_op    (cap_op),
    .oe        (oe),
    .rvalid    (rvalid)
  );

  // R1: a read taken with snooze low on both edges is presented after the second
  p_read_lat_r1: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_req && !hold_req && !snooze) ##1 !snooze |=> (rvalid && oe));

  // R1: a valid word is never presented with the bus disabled
  p_valid_oe_r1: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> oe);

  // R2: a write leaves the bus disabled once it reaches the array
  p_write_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && wr_req) |-> ##2 !oe);

  // R4: read data only moves when a new word is presented
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (rvalid || $stable(rdata)));

  // R7: a deselect always has the bus off two edges after capture
  p_desel_off_r7: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> ##2 (!oe && !rvalid));

  // R8: snooze blanks the outputs at the next edge
  p_snooze_off_r8: assert property (@(posedge clk) disable iff (rst)
    snooze |=> (!oe && !rvalid));

  // R10: reset clears the output stage
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!oe && !rvalid && rdata == '0));

endmodule

// File: tb/syncram_rdpipe_tb.sv
module syncram_rdpipe_tb;

  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          dual_desel;
  logic          snooze;
  logic          sel_n;
  logic          wr_req;
  logic          hold_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          oe;
  logic          rvalid;

  int n_run  = 0;
  int n_fail = 0;
  logic [DW-1:0] model [1 << AW];

  syncram_rdpipe #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .dual_desel(dual_desel), .snooze(snooze),
    .sel_n(sel_n), .wr_req(wr_req), .hold_req(hold_req), .addr(addr),
    .wdata(wdata), .rdata(rdata), .oe(oe), .rvalid(rvalid)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (act=timeout exp=done)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // op: 0 deselect, 1 read, 2 write, 3 hold. Returns just after the capture edge.
  task automatic issue(input int op, input int a, input int d);
    sel_n    = (op == 0);
    wr_req   = (op == 2);
    hold_req = (op == 3);
    addr     = a[AW-1:0];
    wdata    = d[DW-1:0];
    if (op == 2 && !snooze) model[a] = d[DW-1:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    dual_desel = mode;
    issue(0, 0, 0);
    issue(0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 oe after reset", oe, 0);
    chk("R10 rvalid after reset", rvalid, 0);
    chk("R10 rdata after reset", rdata, 0);
  endtask

  task automatic t_write_read;
    issue(2, 5, 16'hA5C3);
    issue(2, 9, 16'h1234);
    chk("R2 oe low after write", oe, 0);
    issue(2, 17, 16'hBEEF);
    issue(0, 0, 0);
    issue(1, 5, 0);
    issue(0, 0, 0);
    chk("R1 rdata", rdata, model[5]);
    chk("R1 rvalid", rvalid, 1);
    chk("R1 oe", oe, 1);
    issue(0, 0, 0);
    chk("R1 rvalid single cycle", rvalid, 0);
  endtask

  task automatic t_back2back;
    issue(0, 0, 0);
    issue(1, 9, 0);
    chk("R3 oe before data", oe, 0);
    issue(1, 17, 0);
    chk("R3 first word", rdata, model[9]);
    chk("R3 oe on first word", oe, 1);
    issue(0, 0, 0);
    chk("R3 second word", rdata, model[17]);
    chk("R3 oe no gap", oe, 1);
    chk("R3 rvalid second", rvalid, 1);
    issue(0, 0, 0);
    chk("R7 oe off after read+desel", oe, 0);
  endtask

  task automatic t_hold;
    issue(1, 5, 0);
    issue(3, 0, 0);
    chk("R4 word before hold", rdata, model[5]);
    issue(3, 0, 0);
    chk("R4 oe kept on hold", oe, 1);
    chk("R4 rvalid low on hold", rvalid, 0);
    chk("R4 rdata kept on hold", rdata, model[5]);
    issue(0, 0, 0);
    issue(0, 0, 0);
  endtask

  task automatic t_desel_after_hold(input logic mode);
    issue(1, 9, 0);
    issue(3, 0, 0);
    issue(0, 0, 0);
    if (!mode) chk("R5 single-cycle cut", oe, 0);
    else       chk("R6 dual-cycle still on", oe, 1);
    issue(0, 0, 0);
    if (mode)  chk("R6 dual-cycle off next edge", oe, 0);
    else       chk("R5 stays off", oe, 0);
  endtask

  task automatic t_read_then_desel(input logic mode);
    issue(1, 17, 0);
    issue(0, 0, 0);
    chk(mode ? "R7 word kept (dual)" : "R7 word kept (single)", rdata, model[17]);
    chk("R7 oe with word", oe, 1);
    issue(0, 0, 0);
    chk("R7 oe off", oe, 0);
    chk("R7 rvalid off", rvalid, 0);
  endtask

  task automatic t_snooze;
    issue(2, 33, 16'h5A5A);
    issue(0, 0, 0);
    issue(1, 33, 0);
    snooze = 1'b1;
    issue(2, 33, 16'hFFFF);
    chk("R8 in-flight read dropped rvalid", rvalid, 0);
    chk("R8 oe forced low", oe, 0);
    issue(1, 33, 0);
    issue(1, 33, 0);
    chk("R8 read ignored rvalid", rvalid, 0);
    chk("R8 oe still low", oe, 0);
    snooze = 1'b0;
    issue(0, 0, 0);
    issue(1, 33, 0);
    issue(0, 0, 0);
    chk("R8 write ignored / R9 retained", rdata, 16'h5A5A);
    chk("R9 rvalid after snooze", rvalid, 1);
  endtask

  task automatic t_reset_mid;
    issue(1, 5, 0);
    rst = 1'b1;
    issue(0, 0, 0);
    rst = 1'b0;
    chk("R10 oe cleared mid-run", oe, 0);
    chk("R10 rvalid cleared mid-run", rvalid, 0);
    chk("R10 rdata cleared mid-run", rdata, 0);
  endtask

  initial begin
    rst = 1'b1; dual_desel = 1'b0; snooze = 1'b0;
    sel_n = 1'b1; wr_req = 1'b0; hold_req = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    @(negedge clk);
    do_reset(1'b0);
    t_reset();
    t_write_read();
    t_back2back();
    t_hold();
    t_desel_after_hold(1'b0);
    t_read_then_desel(1'b0);
    do_reset(1'b1);
    t_desel_after_hold(1'b1);
    t_read_then_desel(1'b1);
    t_hold();
    t_snooze();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule